// File: doc/BRIEF.md
# Multi-Function Integer ALU with Status Flags

This block is a purely combinational 32-bit integer arithmetic/logic unit. It takes two operands and a 4-bit function code and returns a 32-bit result together with three status flags: a zero flag, a signed-overflow flag and a carry flag. It offers three bitwise functions (AND, OR, NOR) and three arithmetic ones (add, subtract, signed set-on-less-than). Shifts, multiply and divide are handled by other units and are not part of this block.

The datapath is a chain of identical one-bit slices. Each slice holds an AND gate, an OR gate, a full adder and a four-way result selector. A small decoder turns the function code into per-slice controls: invert A, invert B, carry injected into bit 0, and which slice output to pick. Subtraction is A + ~B + 1. NOR is ~A AND ~B. Set-on-less-than takes the sign of A−B, corrects it with the subtraction overflow, and routes that bit into bit 0 of the result. There are no registers and no state. The "operation kind" that the decoder derives (logic, add, sub, compare, none) plays the role a state would play: it is the single selector that every flag rule keys on.

Top module: `alu_core_top`

## Requirements
- R1: Code 4'b0000 gives the bitwise AND of A and B. Code 4'b0001 gives the bitwise OR.
- R2: Code 4'b1100 gives the bitwise NOR of A and B, that is ~(A | B).
- R3: Code 4'b0010 gives (A + B) mod 2^32. The carry flag is the carry out of bit 31.
- R4: Code 4'b0110 gives (A − B) mod 2^32. The carry flag is the carry out of bit 31 of A + ~B + 1, so it is 1 exactly when A ≥ B as unsigned numbers.
- R5: For add and subtract, the overflow flag is 1 exactly when the true signed result of the operation lies outside the signed 32-bit range.
- R6: Code 4'b0111 gives 1 in bit 0 when A < B as signed numbers (correct even when A−B overflows) and 0 in bits 31..1. The overflow flag is 0. The carry flag is the carry of the internal subtraction, as in R4.
- R7: For the three logical codes, the overflow flag and the carry flag are both 0.
- R8: Any other code gives a result of 0, with the overflow and carry flags at 0 (so the zero flag is 1).
- R9: The zero flag is 1 exactly when all 32 result bits are 0, for every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (A) |
| op_b | input | 32 | Second operand (B) |
| func_sel | input | 4 | Function code, encoded as listed in R1 to R8 |
| result | output | 32 | Function result |
| zero_flag | output | 1 | 1 when the result is all zeros |
| ovf_flag | output | 1 | Signed overflow of add or subtract |
| carry_flag | output | 1 | Carry out of bit 31 for arithmetic codes |

## Verification
The assertions check four kinds of behaviour on every input change. They check that the upper bits of a compare are clear, that logical and undefined codes keep both flags low and undefined codes keep the result zero, that any reported add or subtract overflow matches the operand and result signs, and that the zero flag agrees with the result. The exact arithmetic values are left to the bench, which compares them against a wide-integer model under random and directed operands. These values are the sum, the difference, the unsigned carry and borrow sense, and the signed compare result across overflowing operand pairs.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned CODE_W = 4;

    // Function codes (fixed encoding)
    localparam logic [CODE_W-1:0] FN_AND = 4'b0000;
    localparam logic [CODE_W-1:0] FN_OR  = 4'b0001;
    localparam logic [CODE_W-1:0] FN_ADD = 4'b0010;
    localparam logic [CODE_W-1:0] FN_SUB = 4'b0110;
    localparam logic [CODE_W-1:0] FN_SLT = 4'b0111;
    localparam logic [CODE_W-1:0] FN_NOR = 4'b1100;

    // Per-slice output selector
    typedef enum logic [1:0] {
        PICK_AND  = 2'd0,
        PICK_OR   = 2'd1,
        PICK_SUM  = 2'd2,
        PICK_LESS = 2'd3
    } pick_e;

    // Operation kind, drives the flag rules
    typedef enum logic [2:0] {
        KIND_LOGIC = 3'd0,
        KIND_ADD   = 3'd1,
        KIND_SUB   = 3'd2,
        KIND_CMP   = 3'd3,
        KIND_NONE  = 3'd4
    } kind_e;

    typedef struct packed {
        logic  inv_a;
        logic  inv_b;
        logic  carry_in;
        pick_e pick;
        kind_e kind;
    } slice_ctl_t;

endpackage

// File: rtl/alu_func_decode.sv
module alu_func_decode
    import alu_pkg::*;
#(
    parameter int unsigned CODE_WIDTH = CODE_W
) (
    input  logic [CODE_WIDTH-1:0] func_code,
    output slice_ctl_t            ctl
);

    always_comb begin
        ctl = '{inv_a: 1'b0, inv_b: 1'b0, carry_in: 1'b0,
                pick: PICK_LESS, kind: KIND_NONE};
        unique case (func_code)
            FN_AND: begin
                ctl.pick = PICK_AND;
                ctl.kind = KIND_LOGIC;
            end
            FN_OR: begin
                ctl.pick = PICK_OR;
                ctl.kind = KIND_LOGIC;
            end
            FN_NOR: begin
                ctl.inv_a = 1'b1;
                ctl.inv_b = 1'b1;
                ctl.pick  = PICK_AND;
                ctl.kind  = KIND_LOGIC;
            end
            FN_ADD: begin
                ctl.pick = PICK_SUM;
                ctl.kind = KIND_ADD;
            end
            FN_SUB: begin
                ctl.inv_b    = 1'b1;
                ctl.carry_in = 1'b1;
                ctl.pick     = PICK_SUM;
                ctl.kind     = KIND_SUB;
            end
            FN_SLT: begin
                ctl.inv_b    = 1'b1;
                ctl.carry_in = 1'b1;
                ctl.pick     = PICK_LESS;
                ctl.kind     = KIND_CMP;
            end
            default: begin
                // undefined code: the less path is held at 0, so the result is 0
                ctl.pick = PICK_LESS;
                ctl.kind = KIND_NONE;
            end
        endcase
    end

    // An inverted B must always come with an injected carry, except for NOR
    always_comb begin
        if (ctl.inv_b && ctl.kind != KIND_LOGIC)
            AST_SUB_CARRY_INJECT: assert (ctl.carry_in)
                else $error("subtract path without carry injection"); // R4
    end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic  a_bit,
    input  logic  b_bit,
    input  logic  inv_a,
    input  logic  inv_b,
    input  logic  c_in,
    input  logic  less_in,
    input  pick_e pick,
    output logic  b_eff,
    output logic  sum_bit,
    output logic  c_out,
    output logic  res_bit
);

    logic a_eff;

    always_comb begin
        a_eff   = a_bit ^ inv_a;
        b_eff   = b_bit ^ inv_b;
        sum_bit = a_eff ^ b_eff ^ c_in;
        c_out   = (a_eff & b_eff) | (a_eff & c_in) | (b_eff & c_in);
    end

    always_comb begin
        unique case (pick)
            PICK_AND:  res_bit = a_eff & b_eff;
            PICK_OR:   res_bit = a_eff | b_eff;
            PICK_SUM:  res_bit = sum_bit;
            PICK_LESS: res_bit = less_in;
            default:   res_bit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  kind_e            kind,
    input  logic             a_msb,
    input  logic             b_msb,
    input  logic             b_eff_msb,
    input  logic             sum_msb,
    input  logic             msb_carry,
    input  logic [WIDTH-1:0] result,
    output logic             cmp_bit,
    output logic             zero_flag,
    output logic             ovf_flag,
    output logic             carry_flag
);

    logic sign_ovf;
    logic arith;

    always_comb begin
        // same-sign addends whose sum changes sign
        sign_ovf   = (a_msb == b_eff_msb) && (sum_msb != a_msb);
        arith      = (kind == KIND_ADD) || (kind == KIND_SUB) || (kind == KIND_CMP);
        cmp_bit    = (kind == KIND_CMP) ? (sum_msb ^ sign_ovf) : 1'b0;
        ovf_flag   = ((kind == KIND_ADD) || (kind == KIND_SUB)) ? sign_ovf : 1'b0;
        carry_flag = arith ? msb_carry : 1'b0;
        zero_flag  = ~|result;
    end

    always_comb begin
        if (kind == KIND_SUB && ovf_flag)
            AST_SUB_OVF_SIGNS: assert ((a_msb != b_msb) && (sum_msb != a_msb))
                else $error("subtract overflow with inconsistent signs"); // R5
        if (kind == KIND_CMP)
            AST_CMP_NO_OVF: assert (!ovf_flag)
                else $error("compare reported overflow"); // R6
    end

endmodule

// File: rtl/alu_core_top.sv
module alu_core_top
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH      = DATA_W,
    parameter int unsigned CODE_WIDTH = CODE_W
) (
    input  logic [WIDTH-1:0]      op_a,
    input  logic [WIDTH-1:0]      op_b,
    input  logic [CODE_WIDTH-1:0] func_sel,
    output logic [WIDTH-1:0]      result,
    output logic                  zero_flag,
    output logic                  ovf_flag,
    output logic                  carry_flag
);

    localparam int unsigned MSB = WIDTH - 1;

    slice_ctl_t       ctl;
    logic             carry [0:WIDTH];
    logic [WIDTH-1:0] sum_vec;
    logic [WIDTH-1:0] b_eff_vec;
    logic [WIDTH-1:0] res_vec;
    logic             cmp_bit;

    alu_func_decode #(.CODE_WIDTH(CODE_WIDTH)) u_decode (
        .func_code (func_sel),
        .ctl       (ctl)
    );

    assign carry[0] = ctl.carry_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic less_i;
        if (i == 0) begin : g_lsb
            assign less_i = cmp_bit;
        end else begin : g_upper
            assign less_i = 1'b0;
        end
        alu_bit_slice u_slice (
            .a_bit   (op_a[i]),
            .b_bit   (op_b[i]),
            .inv_a   (ctl.inv_a),
            .inv_b   (ctl.inv_b),
            .c_in    (carry[i]),
            .less_in (less_i),
            .pick    (ctl.pick),
            .b_eff   (b_eff_vec[i]),
            .sum_bit (sum_vec[i]),
            .c_out   (carry[i+1]),
            .res_bit (res_vec[i])
        );
    end

    alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .kind       (ctl.kind),
        .a_msb      (op_a[MSB]),
        .b_msb      (op_b[MSB]),
        .b_eff_msb  (b_eff_vec[MSB]),
        .sum_msb    (sum_vec[MSB]),
        .msb_carry  (carry[WIDTH]),
        .result     (res_vec),
        .cmp_bit    (cmp_bit),
        .zero_flag  (zero_flag),
        .ovf_flag   (ovf_flag),
        .carry_flag (carry_flag)
    );

    assign result = res_vec;

    always_comb begin
        if (func_sel == FN_SLT)
            AST_CMP_UPPER_CLEAR: assert (result[MSB:1] == '0)
                else $error("compare result has upper bits set"); // R6
        if (func_sel == FN_AND || func_sel == FN_OR || func_sel == FN_NOR)
            AST_LOGIC_QUIET_FLAGS: assert (!ovf_flag && !carry_flag)
                else $error("logical code raised a flag"); // R7
        if (ctl.kind == KIND_NONE)
            AST_UNDEF_ZERO: assert (result == '0 && !ovf_flag && !carry_flag)
                else $error("undefined code produced output"); // R8
        if (func_sel == FN_ADD && ovf_flag)
            AST_ADD_OVF_SIGNS: assert ((op_a[MSB] == op_b[MSB]) && (result[MSB] != op_a[MSB]))
                else $error("add overflow with inconsistent signs"); // R5
        if (zero_flag)
            AST_ZERO_MEANS_CLEAR: assert (result == '0)
                else $error("zero flag with nonzero result"); // R9
    end

endmodule

// File: tb/alu_core_top_tb.sv
module alu_core_top_tb_top;

    logic        clk = 1'b0;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic [3:0]  func_sel;
    logic [31:0] result;
    logic        zero_flag;
    logic        ovf_flag;
    logic        carry_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    alu_core_top dut_i (
        .op_a       (op_a),
        .op_b       (op_b),
        .func_sel   (func_sel),
        .result     (result),
        .zero_flag  (zero_flag),
        .ovf_flag   (ovf_flag),
        .carry_flag (carry_flag)
    );

    // ---------------- reference model ----------------
    function automatic logic [31:0] exp_res(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
        case (f)
            4'b0000: return a & b;
            4'b0001: return a | b;
            4'b1100: return ~(a | b);
            4'b0010: return a + b;
            4'b0110: return a - b;
            4'b0111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic exp_ovf(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint t;
        if (f == 4'b0010)      t = sa + sb;
        else if (f == 4'b0110) t = sa - sb;
        else return 1'b0;
        return (t > 64'sd2147483647) || (t < -64'sd2147483648);
    endfunction

    function automatic logic exp_carry(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
        logic [32:0] w;
        if (f == 4'b0010) begin
            w = {1'b0, a} + {1'b0, b};
            return w[32];
        end
        if (f == 4'b0110 || f == 4'b0111) return a >= b;
        return 1'b0;
    endfunction

    function automatic string req_of(input logic [3:0] f);
        case (f)
            4'b0000, 4'b0001: return "R1";
            4'b1100:          return "R2";
            4'b0010:          return "R3";
            4'b0110:          return "R4";
            4'b0111:          return "R6";
            default:          return "R8";
        endcase
    endfunction

    function automatic string flag_req(input logic [3:0] f);
        case (f)
            4'b0010, 4'b0110: return "R5";
            4'b0111:          return "R6";
            4'b0000, 4'b0001, 4'b1100: return "R7";
            default:          return "R8";
        endcase
    endfunction

    task automatic check_bit(input string tag, input string what, input logic got, input logic want);
        n_checks++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b (f=%b a=%h b=%h)",
                     tag, what, got, want, func_sel, op_a, op_b);
        end
    endtask

    task automatic apply(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        @(negedge clk);
        func_sel = f;
        op_a     = a;
        op_b     = b;
        #2;
        r = exp_res(f, a, b);
        n_checks++;
        if (result !== r) begin
            n_fail++;
            $display("FAIL %s result: actual %h expected %h (f=%b a=%h b=%h)",
                     req_of(f), result, r, f, a, b);
        end
        check_bit("R9", "zero", zero_flag, (r == 32'd0));
        check_bit(flag_req(f), "overflow", ovf_flag, exp_ovf(f, a, b));
        check_bit((f == 4'b0010) ? "R3" : (f == 4'b0110) ? "R4" : flag_req(f),
                  "carry", carry_flag, exp_carry(f, a, b));
    endtask

    function automatic logic [31:0] pick_operand();
        case ($urandom_range(0, 7))
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'(1) << $urandom_range(0, 31);
            default: return $urandom();
        endcase
    endfunction

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd20240611));
        func_sel = 4'b0000;
        op_a     = '0;
        op_b     = '0;

        // idle state: zero operands, AND -> 0 with zero flag (R1, R9)
        apply(4'b0000, 32'h0, 32'h0);
        // R1 patterns
        apply(4'b0000, 32'hF0F0_A5A5, 32'hFF00_0FF0);
        apply(4'b0001, 32'hF0F0_A5A5, 32'h0F0F_0000);
        // R2 NOR, both all-ones and mixed
        apply(4'b1100, 32'h0000_0000, 32'h0000_0000);
        apply(4'b1100, 32'h1234_5678, 32'h8000_0001);
        apply(4'b1100, 32'hFFFF_0000, 32'h0000_FFFF);
        // R3 wrap with carry, R5 positive overflow
        apply(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001);
        apply(4'b0010, 32'h7FFF_FFFF, 32'h0000_0001);
        apply(4'b0010, 32'h8000_0000, 32'h8000_0000);
        // R4 borrow sense and R5 subtract overflow
        apply(4'b0110, 32'h0000_0005, 32'h0000_0005);
        apply(4'b0110, 32'h0000_0000, 32'h0000_0001);
        apply(4'b0110, 32'h8000_0000, 32'h0000_0001);
        apply(4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        // R6 compare across overflowing pairs
        apply(4'b0111, 32'h8000_0000, 32'h0000_0001);
        apply(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
        apply(4'b0111, 32'hFFFF_FFFF, 32'h0000_0000);
        apply(4'b0111, 32'h0000_0003, 32'h0000_0003);
        // R8 undefined codes with operands that would otherwise give output
        for (int c = 0; c < 16; c++) begin
            apply(4'(c), 32'hFFFF_FFFF, 32'h7FFF_FFFF);
        end

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] f;
            case ($urandom_range(0, 6))
                0: f = 4'b0000;
                1: f = 4'b0001;
                2: f = 4'b0010;
                3: f = 4'b0110;
                4: f = 4'b0111;
                5: f = 4'b1100;
                default: f = 4'($urandom_range(0, 15));
            endcase
            apply(f, pick_operand(), pick_operand());
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule